// File: doc/BRIEF.md
# Converter Power-Sequencing Register Controller

This block keeps the power and clock-mode settings of an audio converter in two small byte registers on a plain address/data bus. It turns those settings into enable lines for the reference, the ADC with its microphone amplifier, the microphone supply, the PLL and the master-clock output. It also passes the PLL mode, the master/slave choice and the PLL reference-clock selection on to the clocking logic.

A guard refuses to drop the common reference while anything that depends on it is still running. It records each refused attempt in a flag that clears when read. After the ADC is switched on, converted data is held at zero until a fixed number of sample periods has passed. Those periods are counted on a one-cycle sample-rate strobe. An active-low hardware power-down input overrides everything: it turns every enable off at once and returns the registers to their defaults.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After reset, address 0x10 reads 0x00, address 0x11 reads 0x24 (reference select 4'b1001), address 0x12 reads 0x00. The PLL reference-select output is 4'b1001 and every enable output is 0.
- R2: Address 0x10 holds bit 0 reference, bit 1 ADC, bit 2 mic supply and bit 3 clock-out enables, and bits 7:4 read 0. Address 0x11 holds bit 0 PLL enable, bit 1 master (1) / slave (0) and bits 5:2 reference select, and bits 7:6 read 0. Read data appears on rdata one cycle after rd_en.
- R3: Enable, master and reference-select outputs follow the register bits from the clock edge that accepts the write.
- R4: A write to 0x10 that would turn the reference bit from 1 to 0 keeps it at 1 when, after that write, the ADC, mic or clock-out bit or the PLL bit is set. The other bits of the write take effect.
- R5: A refused clear sets bit 0 of address 0x12. A read of 0x12 returns the flag and then clears it.
- R6: The ADC ready output rises on the edge of the INIT_PERIODS-th strobe (default 3088) counted while the ADC enable is 1. It is 0 before that edge.
- R7: Clearing the ADC enable drops ready and discards the count. The next enable restarts the count from zero.
- R8: While pdn_n is 0, every enable and ready output is 0. One edge later all registers and the error flag hold their defaults.
- R9: When the reference, ADC, PLL and clock-out bits are all 0, the mic supply output is 0, but the mic bit keeps its stored value.
- R10: Reads of addresses other than 0x10 to 0x12 return 0x00, and writes to them change nothing.
- R11: adc_dout equals adc_din while ready is 1, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_n | input | 1 | Hardware power-down, active low |
| fs_strobe | input | 1 | One-cycle pulse per sample period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, one cycle after rd_en |
| en_ref | output | 1 | Common reference enable |
| en_adc | output | 1 | ADC and mic amplifier enable |
| en_mic | output | 1 | Microphone supply enable |
| en_pll | output | 1 | PLL enable (1 = PLL mode, 0 = external clock) |
| en_clkout | output | 1 | Master clock output enable |
| master_mode | output | 1 | 1 = master, 0 = slave |
| pll_refsel | output | 4 | PLL reference clock select |
| adc_ready | output | 1 | Initialisation interval finished |
| adc_din | input | DATA_W | Raw ADC data |
| adc_dout | output | DATA_W | Gated ADC data |

## Verification
Enable and mode outputs change on the edge that accepts a write. The bench drives each write on a falling edge and checks the outputs on the next falling edge. Read data is due one edge after rd_en. Each read pushes its expected byte into a queue, and a monitor pops and compares on the falling edge after the read edge. The ready flag is due on the edge of the last counted strobe, so the bench checks it after one strobe short of the count (still low) and again after the final strobe (high). Power-down gating acts within the same cycle and is checked one time step after pdn_n falls; the register defaults are read back only after a later edge.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam logic [7:0] ADDR_PWR = 8'h10;
    localparam logic [7:0] ADDR_CLK = 8'h11;
    localparam logic [7:0] ADDR_ERR = 8'h12;

    localparam logic [3:0] REFSEL_DEFAULT = 4'b1001;

    // packed so that bit 0 is the reference enable
    typedef struct packed {
        logic clko_en;
        logic mic_en;
        logic adc_en;
        logic ref_en;
    } pwr_reg_t;

    // packed so that bit 0 is PLL enable, bit 1 master, bits 5:2 refsel
    typedef struct packed {
        logic [3:0] refsel;
        logic       master;
        logic       pll_en;
    } clk_reg_t;

endpackage

// File: rtl/pwrseq_regs.sv
module pwrseq_regs
    import pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output pwr_reg_t   pwr,
    output clk_reg_t   clkcfg
);

    typedef struct packed {
        pwr_reg_t   pwr;
        clk_reg_t   clk;
        logic       err;
        logic [7:0] rdata;
    } state_t;

    localparam state_t ST_RESET = '{
        pwr:   '0,
        clk:   '{refsel: REFSEL_DEFAULT, master: 1'b0, pll_en: 1'b0},
        err:   1'b0,
        rdata: 8'h00
    };

    state_t   s_d, s_q;
    pwr_reg_t wr_pwr_d;
    logic     deps_d;
    logic     refuse_d;
    logic     unused_wbits;

    assign unused_wbits = ^wdata[7:6];

    always_comb begin
        s_d      = s_q;
        wr_pwr_d = pwr_reg_t'(wdata[3:0]);
        deps_d   = wr_pwr_d.adc_en | wr_pwr_d.mic_en | wr_pwr_d.clko_en | s_q.clk.pll_en;
        refuse_d = s_q.pwr.ref_en & ~wr_pwr_d.ref_en & deps_d;

        if (rd_en) begin
            case (addr)
                ADDR_PWR: s_d.rdata = {4'b0000, s_q.pwr};
                ADDR_CLK: s_d.rdata = {2'b00, s_q.clk};
                ADDR_ERR: s_d.rdata = {7'b0000000, s_q.err};
                default:  s_d.rdata = 8'h00;
            endcase
            if (addr == ADDR_ERR) begin
                s_d.err = 1'b0;
            end
        end

        if (wr_en && addr == ADDR_PWR) begin
            s_d.pwr = wr_pwr_d;
            if (refuse_d) begin
                s_d.pwr.ref_en = 1'b1;
                s_d.err        = 1'b1;
            end
        end

        if (wr_en && addr == ADDR_CLK) begin
            s_d.clk = clk_reg_t'(wdata[5:0]);
        end

        if (!pdn_n) begin
            s_d = ST_RESET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= ST_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata  = s_q.rdata;
    assign pwr    = s_q.pwr;
    assign clkcfg = s_q.clk;

    // reference only drops when nothing depending on it is left on
    assert_ref_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.pwr.ref_en) |-> !(s_q.pwr.adc_en || s_q.pwr.mic_en ||
                                    s_q.pwr.clko_en || s_q.clk.pll_en));

    assert_err_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.err) |-> $past(wr_en && addr == ADDR_PWR));

    assert_pdn_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_n |=> (s_q.pwr == '0 && s_q.clk.refsel == REFSEL_DEFAULT &&
                    !s_q.clk.master && !s_q.clk.pll_en && !s_q.err));

endmodule

// File: rtl/pwrseq_init_timer.sv
module pwrseq_init_timer #(
    parameter int INIT_PERIODS = 3088
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic strobe,
    output logic ready
);

    localparam int CW = (INIT_PERIODS > 1) ? $clog2(INIT_PERIODS) : 1;
    localparam logic [CW-1:0] LAST = CW'(INIT_PERIODS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!enable) begin
            t_d.cnt  = '0;
            t_d.done = 1'b0;
        end else if (strobe && !t_q.done) begin
            if (t_q.cnt == LAST) begin
                t_d.done = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign ready = t_q.done & enable;

    assert_done_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_q.done) |-> $past(strobe && enable));

    assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!t_q.done && t_q.cnt == '0));

endmodule

// File: rtl/pwrseq_gate.sv
module pwrseq_gate
    import pwrseq_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              pdn_n,
    input  pwr_reg_t          pwr,
    input  clk_reg_t          clkcfg,
    input  logic              ready,
    input  logic [DATA_W-1:0] din,
    output logic              en_ref,
    output logic              en_adc,
    output logic              en_mic,
    output logic              en_pll,
    output logic              en_clkout,
    output logic [DATA_W-1:0] dout
);

    logic any_core_on;

    assign any_core_on = pwr.ref_en | pwr.adc_en | clkcfg.pll_en | pwr.clko_en;

    assign en_ref    = pdn_n & pwr.ref_en;
    assign en_adc    = pdn_n & pwr.adc_en;
    assign en_pll    = pdn_n & clkcfg.pll_en;
    assign en_clkout = pdn_n & pwr.clko_en;
    assign en_mic    = pdn_n & pwr.mic_en & any_core_on;
    assign dout      = ready ? din : '0;

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int DATA_W       = 24,
    parameter int INIT_PERIODS = 3088
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pdn_n,
    input  logic              fs_strobe,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              en_ref,
    output logic              en_adc,
    output logic              en_mic,
    output logic              en_pll,
    output logic              en_clkout,
    output logic              master_mode,
    output logic [3:0]        pll_refsel,
    output logic              adc_ready,
    input  logic [DATA_W-1:0] adc_din,
    output logic [DATA_W-1:0] adc_dout
);

    pwr_reg_t pwr_q;
    clk_reg_t clk_q;
    logic     ready_w;

    pwrseq_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .pdn_n  (pdn_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .pwr    (pwr_q),
        .clkcfg (clk_q)
    );

    pwrseq_gate #(.DATA_W(DATA_W)) u_gate (
        .pdn_n     (pdn_n),
        .pwr       (pwr_q),
        .clkcfg    (clk_q),
        .ready     (ready_w),
        .din       (adc_din),
        .en_ref    (en_ref),
        .en_adc    (en_adc),
        .en_mic    (en_mic),
        .en_pll    (en_pll),
        .en_clkout (en_clkout),
        .dout      (adc_dout)
    );

    pwrseq_init_timer #(.INIT_PERIODS(INIT_PERIODS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (en_adc),
        .strobe (fs_strobe),
        .ready  (ready_w)
    );

    assign adc_ready   = ready_w;
    assign master_mode = clk_q.master;
    assign pll_refsel  = clk_q.refsel;

    assert_ready_needs_adc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_ready |-> $past(en_adc));

    assert_pdn_outputs_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_n |-> !(en_ref || en_adc || en_mic || en_pll || en_clkout || adc_ready));

endmodule

// File: tb/pwrseq_ctrl_test.sv
module pwrseq_ctrl_test;

    localparam int DW   = 24;
    localparam int INIT = 3088;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pdn_n = 1'b1;
    logic          fs_strobe = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    addr = 8'h00;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rdata;
    logic          en_ref, en_adc, en_mic, en_pll, en_clkout, master_mode, adc_ready;
    logic [3:0]    pll_refsel;
    logic [DW-1:0] adc_din = '0;
    logic [DW-1:0] adc_dout;

    int total = 0;
    int bad   = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #5 clk = ~clk;

    pwrseq_ctrl #(.DATA_W(DW), .INIT_PERIODS(INIT)) uut (
        .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .fs_strobe(fs_strobe),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .en_ref(en_ref), .en_adc(en_adc), .en_mic(en_mic), .en_pll(en_pll),
        .en_clkout(en_clkout), .master_mode(master_mode), .pll_refsel(pll_refsel),
        .adc_ready(adc_ready), .adc_din(adc_din), .adc_dout(adc_dout)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: read data is due on the falling edge after the read edge
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard: actual=%h expected=none", rdata);
            end else begin
                check(tag_q.pop_front(), {24'h0, rdata}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fs_strobe = 1'b1;
            @(negedge clk);
            fs_strobe = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 enables", {27'h0, en_ref, en_adc, en_mic, en_pll, en_clkout}, 32'h0);
        check("R1 refsel", {28'h0, pll_refsel}, 32'h9);
        check("R1 ready", {31'h0, adc_ready}, 32'h0);
        rd(8'h10, 8'h00, "R1 pwr reg");
        rd(8'h11, 8'h24, "R1 clk reg");
        rd(8'h12, 8'h00, "R1 err reg");

        // R10 undefined addresses
        wr(8'h20, 8'hFF);
        wr(8'h13, 8'hFF);
        rd(8'h20, 8'h00, "R10 undefined read");
        rd(8'h10, 8'h00, "R10 pwr untouched");
        rd(8'h11, 8'h24, "R10 clk untouched");

        // R2/R3 clock register
        wr(8'h11, 8'hFF);
        check("R3 pll", {31'h0, en_pll}, 32'h1);
        check("R3 master", {31'h0, master_mode}, 32'h1);
        check("R3 refsel", {28'h0, pll_refsel}, 32'hF);
        rd(8'h11, 8'h3F, "R2 clk readback");
        wr(8'h11, 8'h24);
        check("R3 slave", {30'h0, master_mode, en_pll}, 32'h0);

        // R9 standby keeps mic bit but holds supply off
        wr(8'h10, 8'h04);
        check("R9 mic off", {31'h0, en_mic}, 32'h0);
        rd(8'h10, 8'h04, "R9 mic kept");
        wr(8'h10, 8'h0C);
        check("R9 mic on", {30'h0, en_mic, en_clkout}, 32'h3);

        // R2/R3 power register
        wr(8'h10, 8'hFF);
        check("R3 all on", {28'h0, en_ref, en_adc, en_mic, en_clkout}, 32'hF);
        rd(8'h10, 8'h0F, "R2 pwr readback");

        // R4/R5 refused reference clear
        wr(8'h10, 8'h02);
        check("R4 ref held", {31'h0, en_ref}, 32'h1);
        rd(8'h10, 8'h03, "R4 ref kept");
        rd(8'h12, 8'h01, "R5 flag set");
        rd(8'h12, 8'h00, "R5 flag cleared");
        wr(8'h10, 8'h00);
        rd(8'h10, 8'h00, "R4 joint clear");
        rd(8'h12, 8'h00, "R5 no flag");
        wr(8'h10, 8'h01);
        wr(8'h11, 8'h25);
        wr(8'h10, 8'h00);
        rd(8'h10, 8'h01, "R4 pll blocks");
        rd(8'h12, 8'h01, "R5 flag pll");
        wr(8'h11, 8'h24);

        // R6/R11 initialisation interval
        adc_din = 24'hABCDEF;
        wr(8'h10, 8'h03);
        strobes(INIT - 1);
        check("R6 not ready", {31'h0, adc_ready}, 32'h0);
        check("R11 masked", {8'h0, adc_dout}, 32'h0);
        strobes(1);
        check("R6 ready", {31'h0, adc_ready}, 32'h1);
        check("R11 pass", {8'h0, adc_dout}, {8'h0, 24'hABCDEF});
        adc_din = 24'h123456;
        #1;
        check("R11 follow", {8'h0, adc_dout}, {8'h0, 24'h123456});

        // R7 abort and restart
        wr(8'h10, 8'h01);
        check("R7 drop", {31'h0, adc_ready}, 32'h0);
        wr(8'h10, 8'h03);
        strobes(1000);
        wr(8'h10, 8'h01);
        wr(8'h10, 8'h03);
        strobes(INIT - 1);
        check("R7 restart pending", {31'h0, adc_ready}, 32'h0);
        strobes(1);
        check("R7 restart ready", {31'h0, adc_ready}, 32'h1);

        // R8 hardware power-down
        wr(8'h10, 8'h02);
        wr(8'h11, 8'h27);
        @(negedge clk);
        pdn_n = 1'b0;
        #1;
        check("R8 outputs off", {26'h0, en_ref, en_adc, en_mic, en_pll, en_clkout, adc_ready}, 32'h0);
        @(negedge clk);
        @(negedge clk);
        pdn_n = 1'b1;
        check("R8 slave", {31'h0, master_mode}, 32'h0);
        rd(8'h10, 8'h00, "R8 pwr default");
        rd(8'h11, 8'h24, "R8 clk default");
        rd(8'h12, 8'h00, "R8 flag default");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: actual=%0d expected=0 pending", exp_q.size());
        end
        finish_run();
    end

endmodule